// File: doc/BRIEF.md
# Windowed Dual-Bank Register File

This block is the byte-addressed register RAM of a small processor core. It holds two banks in one storage array. The lower bank has 256 bytes and is always reachable through an 8-bit direct address. The upper bank is a larger pool of general-purpose RAM. An access reaches the upper bank in one of two ways: through a linear (indirect) address, or through a 32-byte window at direct addresses 0xE0 to 0xFF. The window works only while it is enabled, and a window control register picks which 32-byte upper block it shows.

Each request moves a byte, a 16-bit word or a 32-bit double word, little-endian, on one synchronous port. The lowest 24 direct addresses belong to special registers that live outside this block. Writes there are passed out on a strobe and do not land in the RAM. A word or double word at a misaligned address is refused and flagged.

Top module: `wrf_regfile`

## Requirements
- R1: With the window disabled, a direct address 0x18..0xFF selects lower-bank byte at that address. Lower bytes 0xE0..0xFF are separate storage from every upper-bank byte.
- R2: req_size 0 moves one byte, 1 a word, 2 a double word. The lowest address holds bits 7:0. A write changes only the bytes it covers. Read data bits above the access width are zero.
- R3: With the window enabled, a direct address a in 0xE0..0xFF selects upper byte sel*32 + (a - 0xE0). Direct addresses below 0xE0 still select the lower bank.
- R4: A cycle with wctl_load high loads wctl_enable and wctl_block. Requests from the following cycle use the new setting. After reset the window is disabled.
- R5: With req_linear high, req_addr selects upper byte req_addr whatever the window setting.
- R6: A misaligned request raises rd_err in the next cycle, keeps rd_valid low and leaves all storage and the strobe untouched. Misaligned means a word at an odd address, a double word at an address that is not a multiple of 4, or req_size 3.
- R7: A good direct write to addresses 0x00..0x17 raises sfr_we in the same cycle, with sfr_addr, sfr_size and sfr_wdata copied from the request, and stores nothing. A direct read there returns zero.
- R8: Read data and rd_valid appear one cycle after the request. A write commits on the accepting edge, so a read in the very next cycle returns the new value.
- R9: After reset rd_valid and rd_err are low, and they stay low in any cycle that follows one without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_linear | input | 1 | 1 = linear upper-bank address, 0 = direct address |
| req_size | input | 2 | 0 byte, 1 word, 2 double word, 3 illegal |
| req_addr | input | 9 | Byte address (direct uses bits 7:0) |
| req_wdata | input | 32 | Write data, little-endian |
| wctl_load | input | 1 | Load the window control register |
| wctl_enable | input | 1 | Window enable value to load |
| wctl_block | input | 4 | Upper 32-byte block number to load |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, zero above access width |
| rd_err | output | 1 | Misaligned request flag |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_addr | output | 5 | Special-register byte address |
| sfr_size | output | 2 | Special-register write size |
| sfr_wdata | output | 32 | Special-register write data |

## Verification
The bench goes after five cases. The first is the window edge, where 0xDF must stay in the lower bank while 0xE0 and 0xFF move into the selected block. A decoder with an off-by-one bound would corrupt the neighbouring bank there. The second is a window block change followed by a request in the very next cycle; a late-applied register would show stale data. Misaligned words and double words must leave the model in step: a design that still commits them shows corrupted bytes on later reads. The bench also checks writes to the reserved area, which must strobe out and read back as zero, and sub-width writes, which must not disturb neighbouring bytes.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_BAD   = 2'd3
   } acc_size_e;

   function automatic logic [2:0] size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE:  return 3'd1;
         SZ_WORD:  return 3'd2;
         SZ_DWORD: return 3'd4;
         default:  return 3'd0;
      endcase
   endfunction

   function automatic logic misaligned(acc_size_e s, logic [1:0] lo);
      case (s)
         SZ_BYTE:  return 1'b0;
         SZ_WORD:  return lo[0];
         SZ_DWORD: return |lo;
         default:  return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/wrf_win_ctl.sv
module wrf_win_ctl #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             en_in,
   input  logic [SEL_W-1:0] sel_in,
   output logic             en_q,
   output logic [SEL_W-1:0] sel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (load) begin
         en_q  <= en_in;
         sel_q <= sel_in;
      end
   end

   // R4: a load is visible in the next cycle
   a_r4_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (en_q == $past(en_in) && sel_q == $past(sel_in)));

endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
   import wrf_pkg::*;
#(
   parameter int LOWER_BYTES = 256,
   parameter int UPPER_BYTES = 512,
   parameter int WIN_BASE    = 224,
   parameter int WIN_BYTES   = 32,
   parameter int RSV_BYTES   = 24,
   parameter bit HAS_WINDOW  = 1'b1,
   parameter int ADDR_W      = 9,
   parameter int PA_W        = 10,
   parameter int SEL_W       = 4
) (
   input  logic              linear,
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   input  logic              win_en,
   input  logic [SEL_W-1:0]  win_sel,
   output logic [PA_W-1:0]   phys,
   output logic              is_rsv,
   output logic              bad
);

   localparam int WOFF_W = $clog2(WIN_BYTES);

   logic [7:0]      a8;
   logic            in_win;
   logic [PA_W-1:0] phys_dir;
   logic [PA_W-1:0] phys_lin;

   assign a8 = addr[7:0];

   generate
      if (HAS_WINDOW) begin : g_win
         assign in_win = win_en && (int'(a8) >= WIN_BASE) &&
                         (int'(a8) < WIN_BASE + WIN_BYTES);
      end else begin : g_nowin
         assign in_win = win_en & 1'b0;
      end
   endgenerate

   assign phys_dir = in_win
      ? PA_W'(LOWER_BYTES) + (PA_W'(win_sel) << WOFF_W) + PA_W'(a8[WOFF_W-1:0])
      : PA_W'(a8);
   assign phys_lin = PA_W'(LOWER_BYTES) + PA_W'(addr);

   assign phys   = linear ? phys_lin : phys_dir;
   assign is_rsv = !linear && (int'(a8) < RSV_BYTES);
   assign bad    = misaligned(size, addr[1:0]);

endmodule

// File: rtl/wrf_byte_ram.sv
module wrf_byte_ram #(
   parameter int DEPTH     = 768,
   parameter int PA_W      = 10,
   parameter int RSV_BYTES = 24,
   parameter int LANES     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [PA_W-1:0]    addr,
   input  logic [2:0]         nbytes,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wr_en && l < int'(nbytes))
            mem[addr + PA_W'(l)] <= wdata[8*l +: 8];
         if (rd_en)
            rdata[8*l +: 8] <= (l < int'(nbytes)) ? mem[addr + PA_W'(l)] : 8'h00;
      end
   end

   // R7: the reserved low area never reaches the array
   a_r7_no_reserved_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (addr >= PA_W'(RSV_BYTES)));

   // R6: only naturally aligned writes commit
   a_r6_aligned_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((addr[1:0] & (nbytes[1:0] - 2'd1)) == 2'b00));

endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
   import wrf_pkg::*;
#(
   parameter int UPPER_BYTES = 512,
   parameter int WIN_BASE    = 224,
   parameter int WIN_BYTES   = 32,
   parameter int RSV_BYTES   = 24,
   parameter bit HAS_WINDOW  = 1'b1,
   parameter int ADDR_W      = $clog2(UPPER_BYTES),
   parameter int SEL_W       = $clog2(UPPER_BYTES / WIN_BYTES),
   parameter int RSV_W       = $clog2(RSV_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_linear,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              wctl_load,
   input  logic              wctl_enable,
   input  logic [SEL_W-1:0]  wctl_block,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              rd_err,
   output logic              sfr_we,
   output logic [RSV_W-1:0]  sfr_addr,
   output logic [1:0]        sfr_size,
   output logic [31:0]       sfr_wdata
);

   localparam int LOWER_BYTES = 256;
   localparam int DEPTH       = LOWER_BYTES + UPPER_BYTES;
   localparam int PA_W        = $clog2(DEPTH);

   if (UPPER_BYTES < 256 || (UPPER_BYTES & (UPPER_BYTES - 1)) != 0)
      $error("UPPER_BYTES must be a power of two of at least 256");
   if (WIN_BYTES < 4 || (WIN_BYTES & (WIN_BYTES - 1)) != 0 || WIN_BASE % WIN_BYTES != 0)
      $error("window must be a power-of-two size at a multiple of its size");
   if (WIN_BASE + WIN_BYTES > LOWER_BYTES || WIN_BASE < RSV_BYTES)
      $error("window must sit in the lower bank above the reserved area");
   if (RSV_BYTES % 4 != 0)
      $error("RSV_BYTES must be a multiple of 4");

   acc_size_e       sz;
   logic            win_en, is_rsv, bad;
   logic [SEL_W-1:0] win_sel;
   logic [PA_W-1:0] phys;
   logic            ram_we, ram_re;
   logic [31:0]     ram_rdata;
   logic            zero_q;

   assign sz = acc_size_e'(req_size);

   wrf_win_ctl #(.SEL_W(SEL_W)) u_win (
      .clk(clk), .rst_n(rst_n), .load(wctl_load),
      .en_in(wctl_enable), .sel_in(wctl_block),
      .en_q(win_en), .sel_q(win_sel)
   );

   wrf_addr_map #(
      .LOWER_BYTES(LOWER_BYTES), .UPPER_BYTES(UPPER_BYTES),
      .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES), .RSV_BYTES(RSV_BYTES),
      .HAS_WINDOW(HAS_WINDOW), .ADDR_W(ADDR_W), .PA_W(PA_W), .SEL_W(SEL_W)
   ) u_map (
      .linear(req_linear), .addr(req_addr), .size(sz),
      .win_en(win_en), .win_sel(win_sel),
      .phys(phys), .is_rsv(is_rsv), .bad(bad)
   );

   assign ram_we = req_valid &&  req_write && !bad && !is_rsv;
   assign ram_re = req_valid && !req_write && !bad && !is_rsv;

   wrf_byte_ram #(
      .DEPTH(DEPTH), .PA_W(PA_W), .RSV_BYTES(RSV_BYTES), .LANES(4)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .wr_en(ram_we), .rd_en(ram_re),
      .addr(phys), .nbytes(size_bytes(sz)), .wdata(req_wdata),
      .rdata(ram_rdata)
   );

   assign sfr_we    = req_valid && req_write && !bad && is_rsv;
   assign sfr_addr  = req_addr[RSV_W-1:0];
   assign sfr_size  = req_size;
   assign sfr_wdata = req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
         zero_q   <= 1'b0;
      end else begin
         rd_valid <= req_valid && !req_write && !bad;
         rd_err   <= req_valid && bad;
         zero_q   <= is_rsv;
      end
   end

   assign rd_data = zero_q ? 32'h0 : ram_rdata;

   // R6: an odd word address is refused in the next cycle
   a_r6_odd_word_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd1 && req_addr[0]) |=> (rd_err && !rd_valid));

   // R8: a byte read answers exactly one cycle later
   a_r8_read_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0) |=> rd_valid);

   // R7: the strobe only fires for direct low addresses
   a_r7_strobe_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_we |-> (!req_linear && req_addr[7:0] < 8'(RSV_BYTES)));

   // R9: no response follows an idle cycle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rd_valid && !rd_err));

endmodule

// File: tb/wrf_regfile_bench.sv
`timescale 1ns/1ps
module wrf_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_linear = 0;
   logic [1:0]  req_size = 0;
   logic [8:0]  req_addr = 0;
   logic [31:0] req_wdata = 0;
   logic        wctl_load = 0, wctl_enable = 0;
   logic [3:0]  wctl_block = 0;
   logic        rd_valid, rd_err, sfr_we;
   logic [31:0] rd_data, sfr_wdata;
   logic [4:0]  sfr_addr;
   logic [1:0]  sfr_size;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] m_mem [768];
   bit         m_en = 0;
   int         m_sel = 0;

   always #2.5 clk = ~clk;

   wrf_regfile u_wrf_regfile (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_linear(req_linear), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .wctl_load(wctl_load), .wctl_enable(wctl_enable),
      .wctl_block(wctl_block), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_err(rd_err), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_size(sfr_size), .sfr_wdata(sfr_wdata)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int phys_of(bit lin, int a);
      int a8 = a % 256;
      if (lin) return 256 + (a % 512);
      if (m_en && a8 >= 224) return 256 + m_sel * 32 + (a8 - 224);
      return a8;
   endfunction

   function automatic int nb(int s);
      return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
   endfunction

   function automatic bit is_bad(int s, int a);
      return (s == 3) || (s == 1 && a % 2 != 0) || (s == 2 && a % 4 != 0);
   endfunction

   function automatic string tag_of(bit lin, int s, int a);
      if (is_bad(s, a)) return "R6";
      if (!lin && a % 256 < 24) return "R7";
      if (lin) return "R5";
      if (m_en && a % 256 >= 224) return "R3";
      return (s == 0) ? "R1" : "R2";
   endfunction

   task automatic access(bit wr, bit lin, int s, int a, logic [31:0] wd,
                         output logic [31:0] got);
      bit bad = is_bad(s, a);
      bit rsv = !lin && (a % 256 < 24);
      int p = phys_of(lin, a);
      string t = tag_of(lin, s, a);
      logic [31:0] exp = 32'h0;
      req_valid = 1; req_write = wr; req_linear = lin;
      req_size = 2'(s); req_addr = 9'(a); req_wdata = wd;
      #1;
      check({t, " strobe"}, {31'h0, sfr_we}, {31'h0, wr && !bad && rsv});
      if (wr && !bad && rsv) begin
         check("R7 sfr_addr", {27'h0, sfr_addr}, {27'h0, 5'(a)});
         check("R7 sfr_data", sfr_wdata, wd);
         check("R7 sfr_size", {30'h0, sfr_size}, {30'h0, 2'(s)});
      end
      if (!rsv && !bad && !wr)
         for (int i = 0; i < nb(s); i++) exp[8*i +: 8] = m_mem[p + i];
      if (!rsv && !bad && wr)
         for (int i = 0; i < nb(s); i++) m_mem[p + i] = wd[8*i +: 8];
      @(negedge clk);
      got = rd_data;
      check({t, " err"}, {31'h0, rd_err}, {31'h0, bad});
      check({t, " valid"}, {31'h0, rd_valid}, {31'h0, !wr && !bad});
      if (!wr && !bad) check({t, " data"}, rd_data, exp);
      req_valid = 0;
   endtask

   task automatic set_win(bit en, int sel);
      wctl_load = 1; wctl_enable = en; wctl_block = 4'(sel);
      @(negedge clk);
      wctl_load = 0;
      m_en = en; m_sel = sel;
   endtask

   initial begin
      logic [31:0] g;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R9 reset valid", {31'h0, rd_valid}, 32'h0);
      check("R9 reset err", {31'h0, rd_err}, 32'h0);
      check("R9 reset strobe", {31'h0, sfr_we}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      for (int a = 0; a < 512; a += 4) access(1, 1, 2, a, $urandom, g);
      for (int a = 24; a < 256; a += 4) access(1, 0, 2, a, $urandom, g);
      // R4: window is disabled after reset, so 0xE0 reads the lower bank
      access(0, 0, 2, 224, 0, g);
      // R3: window edges
      set_win(1, 5);
      access(1, 0, 0, 8'hDF, 32'hA5, g);
      access(1, 0, 0, 8'hE0, 32'h3C, g);
      access(1, 0, 2, 8'hFC, 32'hDEADBEEF, g);
      access(0, 1, 2, 5 * 32 + 28, 0, g);
      access(0, 0, 0, 8'hDF, 0, g);
      // R4: block change used by the very next request
      set_win(1, 9);
      access(0, 0, 2, 8'hE0, 0, g);
      set_win(0, 9);
      access(0, 0, 2, 8'hE0, 0, g);
      // R8: write then read next cycle
      access(1, 0, 1, 8'h40, 32'h0000BEAD, g);
      access(0, 0, 1, 8'h40, 0, g);
      // R2: byte write leaves neighbours alone
      access(1, 0, 0, 8'h45, 32'hFFFFFF77, g);
      access(0, 0, 2, 8'h44, 0, g);
      // R6: misaligned requests change nothing
      access(1, 0, 1, 8'h41, 32'h11112222, g);
      access(1, 1, 2, 6, 32'h33334444, g);
      access(1, 0, 3, 8'h40, 32'h55556666, g);
      access(0, 0, 2, 8'h40, 0, g);
      access(0, 1, 2, 4, 0, g);
      // R7: reserved area
      access(1, 0, 2, 8'h14, 32'h12345678, g);
      access(0, 0, 2, 8'h14, 0, g);
      access(1, 0, 0, 8'h00, 32'h9A, g);
      for (int k = 0; k < 3000; k++) begin
         int r = $urandom % 100;
         int s = ($urandom % 16 == 0) ? 3 : $urandom % 3;
         bit lin = ($urandom % 3 == 0);
         int a = lin ? $urandom % 512 : $urandom % 256;
         if ($urandom % 5 != 0 && s != 3) a = a - (a % nb(s));
         if (r < 4) set_win($urandom % 2, $urandom % 16);
         else access(r < 50, lin, s, a, $urandom, g);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule